// File: doc/BRIEF.md
# Multi-Channel Event and Interrupt Register File

This block keeps the per-channel control state of a DMA event controller with 64 channels and exposes it to software as 32-bit words. Each channel owns one bit in every state vector; the vectors are 64 bits wide and are read and written as a low word (channels 0..31) and a high word (channels 32..63). Hardware event pulses are latched per channel. Software can raise a trigger of its own, withdraw pending triggers, and pause or resume hardware triggering with an enable mask. Every state vector that software changes has a set view, a clear view, or both. In each of them a one bit acts and a zero bit leaves the channel alone.

A lowest-channel-first picker hands one triggered channel per cycle to a downstream sequencer while that sequencer signals ready. A forwarded channel is marked as in flight until software or a completion for it clears the mark. A fresh hardware event on a channel that is already pending or in flight is recorded as missed and raises an error pulse. Completion codes from the sequencer fill an interrupt-pending vector. An interrupt pulse is sent when the enabled pending set turns non-empty, and again on request through a re-evaluate strobe. The error pulse has a strobe of the same kind.

Top module: `dma_evt_regfile`

## Requirements
- R1: A pulse on `evt_in[n]` makes channel n read as pending in the event view (id 0) from the next cycle on. The event view shows hardware-latched and software-set triggers OR-ed together. Writing ones to the event-clear view (id 2) drops both kinds of trigger, and such a clear wins over a hardware event arriving in the same cycle.
- R2: Writing ones to the event-set view (id 1) creates a software trigger. That trigger is forwarded even when the channel's enable bit is clear.
- R3: The enable vector (read at id 3) changes only through its set view (id 4) and its clear view (id 5). A hardware-latched event on a disabled channel stays pending and is not forwarded until the channel is enabled.
- R4: While `fwd_ready` is high and some channel is triggered (hardware event with enable set, or software trigger), `fwd_valid` is high in that same cycle and `fwd_chan` names the lowest such channel. At that clock edge the channel's triggers are cleared and its in-flight bit (read at id 6) is set. While `fwd_ready` is low, nothing is forwarded.
- R5: An in-flight bit is cleared by writing ones to id 7, or by a completion whose code equals the channel number. If a forward sets the bit in the same cycle, the set wins.
- R6: A hardware event that arrives while the channel's latched event bit or in-flight bit is already set sets the channel's missed bit (read at id 8). Writing ones to id 9 clears missed bits; a new miss in the same cycle wins.
- R7: `err_out` is high for one cycle, in the cycle after the edge at which the OR of all missed bits goes from 0 to 1. It is also high in the cycle after a write with data bit 0 set to id 16, if any missed bit is set then.
- R8: `cmp_valid` with code c sets pending bit c (read at id 10). Writing ones to id 11 clears pending bits, and a completion in the same cycle wins. The interrupt enable (read at id 12) has a set view (id 13) and a clear view (id 14).
- R9: `irq_out` is high for one cycle, in the cycle after the edge at which the OR of (pending AND enable) goes from 0 to 1. It is also high in the cycle after a write with data bit 0 set to id 15, if that OR is non-zero then.
- R10: The address is {id[4:0], word}, and word 1 holds channels 32..63. Writes to the read views (ids 0, 3, 6, 8, 10, 12) and to unused ids change nothing. Reads of write-only ids return zero. `rd_data` follows `rd_addr` combinationally.
- R11: After reset every state vector reads zero, and `irq_out`, `err_out` and `fwd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {id, word} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address {id, word} |
| rd_data | output | 32 | Read data, combinational |
| evt_in | input | 64 | Per-channel hardware event pulses |
| cmp_valid | input | 1 | Completion report strobe |
| cmp_code | input | 6 | Channel code of the completion |
| fwd_ready | input | 1 | Downstream sequencer accepts a channel |
| fwd_valid | output | 1 | A channel is forwarded this cycle |
| fwd_chan | output | 6 | Number of the forwarded channel |
| irq_out | output | 1 | One-cycle interrupt pulse |
| err_out | output | 1 | One-cycle missed-event error pulse |

## Verification
The forward outputs depend on the current state and on `fwd_ready` only. They are checked within the same cycle, before the edge at which the input is captured. State vectors change at the edge that captures a write, event or completion, so they are read back through the read port after the next falling edge. The two pulses are due in the cycle that follows the capturing edge and last one cycle, and they are compared at the same point. A cycle-accurate behavioural model in the bench predicts every read view and output for directed sequences (priority order, disabled channels, misses, re-evaluate strobes, ignored writes) and for a long run of random traffic.

// File: rtl/rfm_pkg.sv
`timescale 1ns/10ps
package rfm_pkg;
   localparam int WORD_W = 32;
   localparam int ID_W   = 5;

   typedef enum logic [ID_W-1:0] {
      ID_EVT      = 5'd0,
      ID_EVT_SET  = 5'd1,
      ID_EVT_CLR  = 5'd2,
      ID_ENA      = 5'd3,
      ID_ENA_SET  = 5'd4,
      ID_ENA_CLR  = 5'd5,
      ID_SEC      = 5'd6,
      ID_SEC_CLR  = 5'd7,
      ID_MISS     = 5'd8,
      ID_MISS_CLR = 5'd9,
      ID_PEND     = 5'd10,
      ID_PEND_CLR = 5'd11,
      ID_IENA     = 5'd12,
      ID_IENA_SET = 5'd13,
      ID_IENA_CLR = 5'd14,
      ID_IRQ_EVAL = 5'd15,
      ID_ERR_EVAL = 5'd16
   } reg_id_e;
endpackage

// File: rtl/rfm_pick.sv
`timescale 1ns/10ps
module rfm_pick #(
   parameter int N = 64,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  trig,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   assign any    = |trig;
   assign onehot = trig & (~trig + {{(N-1){1'b0}}, 1'b1});

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (trig[i]) idx = IW'(i);
      end
   end

   // R4: index loop and isolated lowest bit must agree
   always_comb begin
      if (any) begin
         a_r4_pick_agrees: assert (onehot[idx] && trig[idx] && $onehot(onehot));
      end
   end
endmodule

// File: rtl/rfm_pulse.sv
`timescale 1ns/10ps
module rfm_pulse #(
   parameter bit EVAL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic eval_wr,
   output logic pulse
);
   logic lvl_d;
   logic eval_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         eval_q <= 1'b0;
      end else begin
         lvl_d  <= lvl;
         eval_q <= eval_wr;
      end
   end

   generate
      if (EVAL_EN) begin : g_eval
         assign pulse = lvl & (~lvl_d | eval_q);
      end else begin : g_edge
         assign pulse = lvl & ~lvl_d;
      end
   endgenerate

   // R7 / R9: pulse only while the level holds, and on every rise
   a_r9_r7_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> lvl);
   a_r9_r7_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl) |-> pulse);
endmodule

// File: rtl/rfm_chan_bank.sv
`timescale 1ns/10ps
module rfm_chan_bank #(
   parameter int NCH = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt_in,
   input  logic [NCH-1:0] evt_set,
   input  logic [NCH-1:0] evt_clr,
   input  logic [NCH-1:0] ena_set,
   input  logic [NCH-1:0] ena_clr,
   input  logic [NCH-1:0] sec_clr,
   input  logic [NCH-1:0] miss_clr,
   input  logic [NCH-1:0] done_oh,
   input  logic [NCH-1:0] fwd_oh,
   output logic [NCH-1:0] er_q,
   output logic [NCH-1:0] swt_q,
   output logic [NCH-1:0] eer_q,
   output logic [NCH-1:0] ser_q,
   output logic [NCH-1:0] miss_q,
   output logic [NCH-1:0] trig
);
   logic [NCH-1:0] new_miss;

   assign new_miss = evt_in & (er_q | ser_q);
   assign trig     = (er_q & eer_q) | swt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         er_q   <= '0;
         swt_q  <= '0;
         eer_q  <= '0;
         ser_q  <= '0;
         miss_q <= '0;
      end else begin
         er_q   <= (er_q | evt_in) & ~evt_clr & ~fwd_oh;
         swt_q  <= (swt_q & ~evt_clr & ~fwd_oh) | evt_set;
         eer_q  <= (eer_q | ena_set) & ~ena_clr;
         ser_q  <= (ser_q & ~sec_clr & ~done_oh) | fwd_oh;
         miss_q <= (miss_q & ~miss_clr) | new_miss;
      end
   end

   a_r4_fwd_marks_sec: assert property (@(posedge clk) disable iff (!rst_n)
      (|fwd_oh) |=> ((ser_q & $past(fwd_oh)) == $past(fwd_oh)));
   a_r4_fwd_drops_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (|fwd_oh) |=> ((er_q & $past(fwd_oh)) == '0));
   a_r6_miss_captured: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_in & (er_q | ser_q))) |=>
         ((miss_q & $past(evt_in & (er_q | ser_q))) == $past(evt_in & (er_q | ser_q))));
   a_r3_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_set == '0 && ena_clr == '0) |=> $stable(eer_q));
endmodule

// File: rtl/rfm_intr_bank.sv
`timescale 1ns/10ps
module rfm_intr_bank #(
   parameter int NCH = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] done_oh,
   input  logic [NCH-1:0] pend_clr,
   input  logic [NCH-1:0] iena_set,
   input  logic [NCH-1:0] iena_clr,
   output logic [NCH-1:0] pend_q,
   output logic [NCH-1:0] iena_q,
   output logic           lvl
);
   assign lvl = |(pend_q & iena_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         iena_q <= '0;
      end else begin
         pend_q <= (pend_q & ~pend_clr) | done_oh;
         iena_q <= (iena_q & ~iena_clr) | iena_set;
      end
   end

   a_r8_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_oh) |=> ((pend_q & $past(done_oh)) == $past(done_oh)));
   a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_oh == '0 && pend_clr == '0) |=> $stable(pend_q));
endmodule

// File: rtl/dma_evt_regfile.sv
`timescale 1ns/10ps
module dma_evt_regfile
   import rfm_pkg::*;
#(
   parameter int NCH = 64,
   localparam int NW     = NCH / WORD_W,
   localparam int WSEL_W = (NW > 1) ? $clog2(NW) : 1,
   localparam int CW     = $clog2(NCH),
   localparam int AW     = ID_W + WSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic [NCH-1:0]    evt_in,
   input  logic              cmp_valid,
   input  logic [CW-1:0]     cmp_code,
   input  logic              fwd_ready,
   output logic              fwd_valid,
   output logic [CW-1:0]     fwd_chan,
   output logic              irq_out,
   output logic              err_out
);
   generate
      if (NCH % WORD_W != 0 || NCH < 2 * WORD_W) begin : g_bad_nch
         $error("NCH must be a multiple of the word width and hold at least two words");
      end
   endgenerate

   // write decode
   reg_id_e           wid;
   logic [WSEL_W-1:0] wword;
   logic [NCH-1:0]    wmask;

   assign wid   = reg_id_e'(wr_addr[AW-1 -: ID_W]);
   assign wword = wr_addr[WSEL_W-1:0];

   generate
      for (genvar gw = 0; gw < NW; gw++) begin : g_wmask
         assign wmask[gw*WORD_W +: WORD_W] =
            (wr_en && int'(wword) == gw) ? wr_data : '0;
      end
   endgenerate

   logic [NCH-1:0] s_evt_set, s_evt_clr, s_ena_set, s_ena_clr;
   logic [NCH-1:0] s_sec_clr, s_miss_clr, s_pend_clr, s_iena_set, s_iena_clr;
   logic           irq_eval, err_eval;

   assign s_evt_set  = (wid == ID_EVT_SET)  ? wmask : '0;
   assign s_evt_clr  = (wid == ID_EVT_CLR)  ? wmask : '0;
   assign s_ena_set  = (wid == ID_ENA_SET)  ? wmask : '0;
   assign s_ena_clr  = (wid == ID_ENA_CLR)  ? wmask : '0;
   assign s_sec_clr  = (wid == ID_SEC_CLR)  ? wmask : '0;
   assign s_miss_clr = (wid == ID_MISS_CLR) ? wmask : '0;
   assign s_pend_clr = (wid == ID_PEND_CLR) ? wmask : '0;
   assign s_iena_set = (wid == ID_IENA_SET) ? wmask : '0;
   assign s_iena_clr = (wid == ID_IENA_CLR) ? wmask : '0;
   assign irq_eval   = wr_en && wid == ID_IRQ_EVAL && wr_data[0];
   assign err_eval   = wr_en && wid == ID_ERR_EVAL && wr_data[0];

   // completion decode and forwarding
   logic [NCH-1:0] done_oh, fwd_oh, pick_oh, trig;
   logic           pick_any;

   assign done_oh = cmp_valid ? ({{(NCH-1){1'b0}}, 1'b1} << cmp_code) : '0;

   rfm_pick #(.N(NCH)) i_pick (
      .trig   (trig),
      .any    (pick_any),
      .idx    (fwd_chan),
      .onehot (pick_oh)
   );

   assign fwd_valid = fwd_ready & pick_any;
   assign fwd_oh    = fwd_ready ? pick_oh : '0;

   logic [NCH-1:0] er_q, swt_q, eer_q, ser_q, miss_q, pend_q, iena_q;
   logic           ilvl;

   rfm_chan_bank #(.NCH(NCH)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_in),
      .evt_set  (s_evt_set),
      .evt_clr  (s_evt_clr),
      .ena_set  (s_ena_set),
      .ena_clr  (s_ena_clr),
      .sec_clr  (s_sec_clr),
      .miss_clr (s_miss_clr),
      .done_oh  (done_oh),
      .fwd_oh   (fwd_oh),
      .er_q     (er_q),
      .swt_q    (swt_q),
      .eer_q    (eer_q),
      .ser_q    (ser_q),
      .miss_q   (miss_q),
      .trig     (trig)
   );

   rfm_intr_bank #(.NCH(NCH)) i_intr (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_oh  (done_oh),
      .pend_clr (s_pend_clr),
      .iena_set (s_iena_set),
      .iena_clr (s_iena_clr),
      .pend_q   (pend_q),
      .iena_q   (iena_q),
      .lvl      (ilvl)
   );

   rfm_pulse #(.EVAL_EN(1'b1)) i_irq_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (ilvl),
      .eval_wr (irq_eval),
      .pulse   (irq_out)
   );

   rfm_pulse #(.EVAL_EN(1'b1)) i_err_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (|miss_q),
      .eval_wr (err_eval),
      .pulse   (err_out)
   );

   // read mux
   reg_id_e           rid;
   logic [WSEL_W-1:0] rword;
   logic [NCH-1:0]    rvec;

   assign rid   = reg_id_e'(rd_addr[AW-1 -: ID_W]);
   assign rword = rd_addr[WSEL_W-1:0];

   always_comb begin
      case (rid)
         ID_EVT:  rvec = er_q | swt_q;
         ID_ENA:  rvec = eer_q;
         ID_SEC:  rvec = ser_q;
         ID_MISS: rvec = miss_q;
         ID_PEND: rvec = pend_q;
         ID_IENA: rvec = iena_q;
         default: rvec = '0;
      endcase
   end

   assign rd_data = (int'(rword) < NW) ? rvec[int'(rword)*WORD_W +: WORD_W] : '0;

   a_r4_ready_low_holds_events: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_ready && s_evt_clr == '0) |=> ((er_q & $past(er_q)) == $past(er_q)));
   a_r5_done_clears_sec: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !(fwd_valid && fwd_chan == cmp_code)) |=> !ser_q[$past(cmp_code)]);
endmodule

// File: tb/test_dma_evt_regfile.sv
`timescale 1ns/10ps
module test_dma_evt_regfile;
   localparam int NCH = 64;
   localparam int AW  = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            b_wen = 1'b0;
   logic [AW-1:0]   b_waddr = '0;
   logic [31:0]     b_wdata = '0;
   logic [AW-1:0]   b_raddr = '0;
   logic [31:0]     rd_data;
   logic [NCH-1:0]  b_evt = '0;
   logic            b_cv = 1'b0;
   logic [5:0]      b_code = '0;
   logic            b_rdy = 1'b0;
   logic            fwd_valid, irq_out, err_out;
   logic [5:0]      fwd_chan;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [NCH-1:0] m_er = '0, m_swt = '0, m_eer = '0, m_ser = '0, m_miss = '0;
   logic [NCH-1:0] m_pend = '0, m_iena = '0;
   logic           m_irq = 1'b0, m_err = 1'b0;

   always #4 clk = ~clk;

   dma_evt_regfile #(.NCH(NCH)) i_dma_evt_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wen), .wr_addr(b_waddr), .wr_data(b_wdata),
      .rd_addr(b_raddr), .rd_data(rd_data), .evt_in(b_evt), .cmp_valid(b_cv),
      .cmp_code(b_code), .fwd_ready(b_rdy), .fwd_valid(fwd_valid), .fwd_chan(fwd_chan),
      .irq_out(irq_out), .err_out(err_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [NCH-1:0] view(input int id);
      case (id)
         0:  return m_er | m_swt;
         3:  return m_eer;
         6:  return m_ser;
         8:  return m_miss;
         10: return m_pend;
         12: return m_iena;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(input int id);
      case (id)
         0: return "R1 event view";
         3: return "R3 enable view";
         6: return "R5 in-flight view";
         8: return "R6 missed view";
         default: return "R8 interrupt view";
      endcase
   endfunction

   // lowest triggered channel, or -1
   function automatic int exp_pick();
      for (int c = 0; c < NCH; c++) begin
         if ((m_er[c] && m_eer[c]) || m_swt[c]) return c;
      end
      return -1;
   endfunction

   task automatic model_step();
      logic [NCH-1:0] wm, fw, dn, nm;
      int id, p;
      bit old_il, old_ml, new_il, new_ml;
      id = int'(b_waddr[5:1]);
      wm = '0;
      if (b_wen) wm[b_waddr[0]*32 +: 32] = b_wdata;
      p  = b_rdy ? exp_pick() : -1;
      fw = '0;
      if (p >= 0) fw[p] = 1'b1;
      dn = '0;
      if (b_cv) dn[b_code] = 1'b1;
      old_il = |(m_pend & m_iena);
      old_ml = |m_miss;
      nm = '0;
      for (int c = 0; c < NCH; c++) begin
         if (b_evt[c] && (m_er[c] || m_ser[c])) nm[c] = 1'b1;
         m_er[c] = (m_er[c] | b_evt[c]) & !(id == 2 && wm[c]) & !fw[c];
         m_swt[c] = (m_swt[c] & !(id == 2 && wm[c]) & !fw[c]) | (id == 1 && wm[c]);
         if (id == 4 && wm[c]) m_eer[c] = 1'b1;
         if (id == 5 && wm[c]) m_eer[c] = 1'b0;
         if ((id == 7 && wm[c]) || dn[c]) m_ser[c] = 1'b0;
         if (fw[c]) m_ser[c] = 1'b1;
         if (id == 9 && wm[c]) m_miss[c] = 1'b0;
         if (id == 11 && wm[c]) m_pend[c] = 1'b0;
         if (dn[c]) m_pend[c] = 1'b1;
         if (id == 14 && wm[c]) m_iena[c] = 1'b0;
         if (id == 13 && wm[c]) m_iena[c] = 1'b1;
      end
      m_miss = m_miss | nm;
      new_il = |(m_pend & m_iena);
      new_ml = |m_miss;
      m_irq = new_il && (!old_il || (b_wen && id == 15 && b_wdata[0]));
      m_err = new_ml && (!old_ml || (b_wen && id == 16 && b_wdata[0]));
   endtask

   task automatic compare_all();
      int ids[6] = '{0, 3, 6, 8, 10, 12};
      logic [NCH-1:0] v;
      foreach (ids[k]) begin
         v = view(ids[k]);
         for (int w = 0; w < 2; w++) begin
            b_raddr = AW'((ids[k] << 1) | w);
            #0.05;
            chk(tag_of(ids[k]), 64'(rd_data), 64'(v[w*32 +: 32]));
         end
      end
      chk("R9 irq_out", 64'(irq_out), 64'(m_irq));
      chk("R7 err_out", 64'(err_out), 64'(m_err));
   endtask

   // inputs are driven; check forward, take the edge, check state
   task automatic do_cycle();
      int p;
      #0.1;
      p = b_rdy ? exp_pick() : -1;
      chk("R4 fwd_valid", 64'(fwd_valid), 64'(p >= 0));
      if (p >= 0) chk("R4 fwd_chan", 64'(fwd_chan), 64'(p));
      @(posedge clk);
      model_step();
      @(negedge clk);
      #0.5;
      compare_all();
      b_wen = 1'b0;
      b_evt = '0;
      b_cv  = 1'b0;
   endtask

   task automatic wr(input int id, input int w, input logic [31:0] d);
      b_wen = 1'b1;
      b_waddr = AW'((id << 1) | w);
      b_wdata = d;
      do_cycle();
   endtask

   task automatic rd_check(input string tag, input int id, input int w, input logic [31:0] exp);
      b_raddr = AW'((id << 1) | w);
      #0.05;
      chk(tag, 64'(rd_data), 64'(exp));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R11 reset state
      for (int id = 0; id < 17; id++) rd_check("R11 reset view", id, 0, 32'h0);
      rd_check("R11 reset view", 0, 1, 32'h0);
      chk("R11 irq_out", 64'(irq_out), 64'd0);
      chk("R11 err_out", 64'(err_out), 64'd0);
      b_rdy = 1'b1;
      #0.1;
      chk("R11 fwd_valid", 64'(fwd_valid), 64'd0);
      b_rdy = 1'b0;

      // R1 / R3: hardware event on a disabled channel
      b_evt[3] = 1'b1;
      do_cycle();
      b_rdy = 1'b1;
      #0.1;
      chk("R3 disabled channel not forwarded", 64'(fwd_valid), 64'd0);
      do_cycle();
      wr(4, 0, 32'h8);            // enable channel 3
      chk("R4 fwd_chan after enable", 64'(fwd_chan), 64'd3);
      do_cycle();                 // forwarded here
      // R6: event while in flight
      b_evt[3] = 1'b1;
      do_cycle();
      // R5 / R8: completion for channel 3
      b_cv = 1'b1; b_code = 6'd3;
      do_cycle();
      wr(13, 0, 32'h8);           // R9 irq rise
      wr(15, 0, 32'h1);           // R9 re-evaluate
      wr(11, 0, 32'h8);
      wr(15, 0, 32'h1);           // nothing pending: no pulse
      wr(16, 0, 32'h1);           // R7 re-evaluate with miss set
      wr(9, 0, 32'hffff_ffff);
      wr(16, 0, 32'h1);

      // R2: software trigger on disabled channel 40
      b_rdy = 1'b0;
      wr(1, 1, 32'h100);
      b_rdy = 1'b1;
      #0.1;
      chk("R2 software trigger forwarded", 64'(fwd_chan), 64'd40);
      chk("R2 software trigger valid", 64'(fwd_valid), 64'd1);
      do_cycle();

      // R10: writes to read views ignored, write-only views read zero
      b_rdy = 1'b0;
      wr(0, 0, 32'hffff_ffff);
      wr(3, 1, 32'hffff_ffff);
      wr(20, 0, 32'hffff_ffff);
      rd_check("R10 read view write ignored", 0, 0, 32'h0);
      rd_check("R10 read view write ignored", 3, 1, 32'h0);
      wr(1, 1, 32'h8);            // channel 35
      rd_check("R10 high word placement", 0, 1, 32'h8);
      rd_check("R10 write-only reads zero", 1, 1, 32'h0);
      wr(2, 1, 32'h8);
      wr(7, 1, 32'hffff_ffff);
      wr(7, 0, 32'hffff_ffff);

      // R4 priority order
      wr(4, 0, 32'hffff_ffff);
      wr(4, 1, 32'hffff_ffff);
      b_evt[5] = 1'b1; b_evt[9] = 1'b1; b_evt[33] = 1'b1;
      do_cycle();
      b_rdy = 1'b1;
      for (int i = 0; i < 4; i++) do_cycle();

      // random traffic
      for (int i = 0; i < 5000; i++) begin
         b_evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                 & {$urandom, $urandom};
         b_rdy = ($urandom % 10) < 7;
         b_cv = ($urandom % 10) < 3;
         b_code = 6'($urandom);
         if ($urandom % 2 == 1) begin
            b_wen = 1'b1;
            b_waddr = AW'((($urandom % 18) << 1) | ($urandom % 2));
            b_wdata = $urandom & $urandom;
         end
         do_cycle();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule